// File: doc/BRIEF.md
# Byte-Wide Bus Chip-Enable Decoder

This block turns one processor memory access into the select lines for a non-multiplexed byte-wide memory bus. The inputs are a 16-bit address, a flag that marks a code fetch, the read and write strobes, and the current memory configuration. The outputs are four active-low memory chip enables, four active-low peripheral enables, the low address bits for the bus, an active-low write enable, and a flag that sends the access to the multiplexed port bus instead. All outputs are registered and follow the inputs one clock later.

The memory can be built from four 32 KB SRAMs or from one 128 KB SRAM. Code and data are laid out in one physical space. In non-partitioned mode, code fills the lower 64 KB and data fills the upper 64 KB, and each has its own range limit. In partitioned mode, one 64 KB space is split at a boundary: program sits below the boundary and data sits at or above it. A peripheral-select bit maps the whole data space onto four 16 KB peripheral enables. A low-supply reset flag holds every battery-backed select line inactive. A separate code-fetch copy of the first chip enable keeps working during that reset, so it can drive a non-backed program memory.

Top module: `bwbus_cedec`

## Requirements
- R1: While the reset input is low, and until the synchronised release takes effect, all chip enables, peripheral enables, the write enable and the code-fetch copy are high, the port-bus flag is low and the bus address is zero.
- R2: In 32 KB mode (`msel_32k`=1), a decoded memory access drives exactly one chip enable low. The index is physical address bits 16:15, and the physical address is {data access, addr} when not partitioned. `bus_addr` carries addr[14:0]. Outputs appear one cycle after the inputs.
- R3: In 128 KB mode (`msel_32k`=0), `ce_n[0]` goes low for any decoded memory access. `ce_n[1]` carries physical bit 16 and `ce_n[2]` carries physical bit 15. `ce_n[3]` stays high.
- R4: With `pes`=1, every data access is decoded. It drives `pe_n[addr[15:14]]` low and no chip enable. Code fetches are decoded as if `pes`=0.
- R5: `we_n` goes low only for a write that is decoded to a data region. It stays high for code fetches and for partitioned addresses below the boundary.
- R6: While `pf_rst`=1, the chip enables, peripheral enables and write enable are high and the port-bus flag is low. The code-fetch copy still follows its decode.
- R7: In 128 KB mode, `part_en` has no effect: the block decodes as in non-partitioned mode.
- R8: A code fetch above `prog_top` (or at or above `bound` when partitioned), or a data access above `data_top` with `pes`=0, raises `exp_acc` and drives no enable.
- R9: With neither strobe asserted, every enable is high and `exp_acc` is low.
- R10: In partitioned 32 KB mode, code and data share physical addresses 0000h–FFFFh. `ce_n[0]` serves addresses below 8000h and `ce_n[1]` serves addresses from 8000h up.
- R11: `ce1_code_n` goes low only for a decoded code fetch whose physical bits 16:15 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 16 | Access address |
| is_code | input | 1 | 1 = code fetch, 0 = data access |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| msel_32k | input | 1 | 1 = four 32 KB SRAMs, 0 = one 128 KB SRAM |
| part_en | input | 1 | Partitioned layout enable |
| pes | input | 1 | Peripheral select for data accesses |
| pf_rst | input | 1 | Low-supply reset state |
| bound | input | 16 | Partition boundary |
| prog_top | input | 16 | Highest code address on the bus (non-partitioned) |
| data_top | input | 16 | Highest data address on the bus |
| ce_n | output | 4 | Memory chip enables, active low (address bits in 128 KB mode) |
| pe_n | output | 4 | Peripheral enables, active low |
| bus_addr | output | 15 | Byte-wide bus address |
| we_n | output | 1 | Write enable, active low |
| ce1_code_n | output | 1 | Code-fetch copy of the first chip enable, not gated by pf_rst |
| exp_acc | output | 1 | Access routed to the port bus |

## Verification
The properties assume that a read strobe and a write strobe never occur together and that a code fetch is always a read. They also assume that the configuration inputs change only between accesses. The directed tasks keep to these rules: each task sets its configuration first and then issues single reads or writes, one per cycle. Each property looks at inputs one cycle back, and only once the synchronised reset has been released for at least a cycle.

// File: rtl/bwbus_pkg.sv
package bwbus_pkg;
  localparam int unsigned BW_ADDR_W = 16;

  typedef struct packed {
    logic                 on_bus;   // decoded onto the byte-wide bus
    logic                 to_exp;   // routed to the port bus
    logic                 periph;   // data access remapped to peripherals
    logic                 is_prog;  // access lies in program space
    logic                 wr_ok;    // write may be enabled
    logic                 code;     // access is a code fetch
    logic [BW_ADDR_W:0]   phys;     // physical address, one bit wider
  } bw_dec_t;
endpackage

// File: rtl/bwbus_region.sv
module bwbus_region
  import bwbus_pkg::*;
(
  input  logic [BW_ADDR_W-1:0] addr,
  input  logic                 is_code,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic                 msel_32k,
  input  logic                 part_en,
  input  logic                 pes,
  input  logic [BW_ADDR_W-1:0] bound,
  input  logic [BW_ADDR_W-1:0] prog_top,
  input  logic [BW_ADDR_W-1:0] data_top,
  output bw_dec_t              dec
);
  logic access;
  logic part_on;
  logic periph;
  logic below_bnd;
  logic in_range;

  always_comb begin
    access    = rd_stb | wr_stb;
    part_on   = part_en & msel_32k;   // partitioning needs the 32 KB layout
    periph    = pes & ~is_code;
    below_bnd = addr < bound;

    if (is_code) begin
      in_range = part_on ? below_bnd : (addr <= prog_top);
    end else begin
      in_range = periph | (addr <= data_top);
    end

    dec.code    = is_code;
    dec.periph  = periph;
    dec.on_bus  = access & in_range;
    dec.to_exp  = access & ~in_range;
    dec.is_prog = is_code | (part_on & ~periph & below_bnd);
    dec.wr_ok   = wr_stb & ~is_code & access & in_range & ~dec.is_prog;
    dec.phys    = part_on ? {1'b0, addr} : {~is_code, addr};
  end
endmodule

// File: rtl/bwbus_select.sv
module bwbus_select
  import bwbus_pkg::*;
#(
  parameter int unsigned N_CE = 4,
  parameter int unsigned N_PE = 4
) (
  input  bw_dec_t              dec,
  input  logic [BW_ADDR_W-1:0] addr,
  input  logic                 msel_32k,
  output logic [N_CE-1:0]      ce_n,
  output logic [N_PE-1:0]      pe_n,
  output logic                 code_ce_n
);
  localparam int unsigned SEL_W = $clog2(N_CE);
  localparam int unsigned PE_W  = $clog2(N_PE);
  localparam int unsigned TOP   = BW_ADDR_W;

  logic [SEL_W-1:0] blk;
  logic [PE_W-1:0]  quad;
  logic             mem_hit;
  logic [N_CE-1:0]  ce32_n;
  logic [N_CE-1:0]  ce128_n;

  assign blk     = dec.phys[TOP -: SEL_W];
  assign quad    = addr[BW_ADDR_W-1 -: PE_W];
  assign mem_hit = dec.on_bus & ~dec.periph;

  genvar g;
  generate
    for (g = 0; g < N_CE; g++) begin : g_ce
      assign ce32_n[g] = ~(mem_hit & (blk == SEL_W'(g)));
      if (g == 0) begin : g_sel
        assign ce128_n[g] = ~mem_hit;
      end else if (g < 3) begin : g_abit
        // upper two pins reused as physical bits 16 and 15
        assign ce128_n[g] = mem_hit ? dec.phys[TOP + 1 - g] : 1'b1;
      end else begin : g_idle
        assign ce128_n[g] = 1'b1;
      end
    end
    for (g = 0; g < N_PE; g++) begin : g_pe
      assign pe_n[g] = ~(dec.on_bus & dec.periph & (quad == PE_W'(g)));
    end
  endgenerate

  assign ce_n      = msel_32k ? ce32_n : ce128_n;
  assign code_ce_n = ~(mem_hit & dec.code & (blk == '0));
endmodule

// File: rtl/bwbus_cedec.sv
module bwbus_cedec
  import bwbus_pkg::*;
#(
  parameter int unsigned N_CE = 4,
  parameter int unsigned N_PE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BW_ADDR_W-1:0] addr,
  input  logic                 is_code,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic                 msel_32k,
  input  logic                 part_en,
  input  logic                 pes,
  input  logic                 pf_rst,
  input  logic [BW_ADDR_W-1:0] bound,
  input  logic [BW_ADDR_W-1:0] prog_top,
  input  logic [BW_ADDR_W-1:0] data_top,
  output logic [N_CE-1:0]      ce_n,
  output logic [N_PE-1:0]      pe_n,
  output logic [BW_ADDR_W-2:0] bus_addr,
  output logic                 we_n,
  output logic                 ce1_code_n,
  output logic                 exp_acc
);
  localparam int unsigned BA_W = BW_ADDR_W - 1;

  logic [1:0] rst_sync_q;
  logic       rst_ok;

  bw_dec_t         dec;
  logic [N_CE-1:0] sel_ce_n;
  logic [N_PE-1:0] sel_pe_n;
  logic            sel_code_n;

  logic [N_CE-1:0] ce_n_d;
  logic [N_PE-1:0] pe_n_d;
  logic [BA_W-1:0] ba_d;
  logic            we_n_d;
  logic            code_n_d;
  logic            exp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  bwbus_region u_region (
    .addr     (addr),
    .is_code  (is_code),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .msel_32k (msel_32k),
    .part_en  (part_en),
    .pes      (pes),
    .bound    (bound),
    .prog_top (prog_top),
    .data_top (data_top),
    .dec      (dec)
  );

  bwbus_select #(.N_CE(N_CE), .N_PE(N_PE)) u_select (
    .dec       (dec),
    .addr      (addr),
    .msel_32k  (msel_32k),
    .ce_n      (sel_ce_n),
    .pe_n      (sel_pe_n),
    .code_ce_n (sel_code_n)
  );

  // next state: low-supply reset parks every battery-backed line
  always_comb begin
    ba_d     = addr[BA_W-1:0];
    code_n_d = sel_code_n;
    if (pf_rst) begin
      ce_n_d = '1;
      pe_n_d = '1;
      we_n_d = 1'b1;
      exp_d  = 1'b0;
    end else begin
      ce_n_d = sel_ce_n;
      pe_n_d = sel_pe_n;
      we_n_d = ~dec.wr_ok;
      exp_d  = dec.to_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ce_n       <= '1;
      pe_n       <= '1;
      bus_addr   <= '0;
      we_n       <= 1'b1;
      ce1_code_n <= 1'b1;
      exp_acc    <= 1'b0;
    end else begin
      ce_n       <= ce_n_d;
      pe_n       <= pe_n_d;
      bus_addr   <= ba_d;
      we_n       <= we_n_d;
      ce1_code_n <= code_n_d;
      exp_acc    <= exp_d;
    end
  end
endmodule

// File: rtl/bwbus_cedec_chk.sv
module bwbus_cedec_chk #(
  parameter int unsigned N_CE = 4,
  parameter int unsigned N_PE = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            pf_rst,
  input logic            is_code,
  input logic            rd_stb,
  input logic            wr_stb,
  input logic            msel_32k,
  input logic            part_en,
  input logic            pes,
  input logic [15:0]     addr,
  input logic [15:0]     bound,
  input logic [N_CE-1:0] ce_n,
  input logic [N_PE-1:0] pe_n,
  input logic            we_n,
  input logic            ce1_code_n,
  input logic            exp_acc
);
  // R6
  pfail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && $past(pf_rst) |-> (&ce_n) && (&pe_n) && we_n && !exp_acc);

  // R5
  prog_wprot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && ($past(is_code) ||
      ($past(part_en) && $past(msel_32k) && !$past(pes) && ($past(addr) < $past(bound))))
    |-> we_n);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && !$past(rd_stb) && !$past(wr_stb)
    |-> (&ce_n) && (&pe_n) && we_n && ce1_code_n && !exp_acc);

  // R3
  ce4_unused_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && !$past(msel_32k) |-> ce_n[N_CE-1]);

  // R2
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && $past(msel_32k) |-> $countones(~{ce_n, pe_n}) <= 1);

  // R8
  exp_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    exp_acc |-> (&ce_n) && (&pe_n) && we_n);

  // R4
  periph_route_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) && $past(pes) && !$past(is_code) && !$past(pf_rst) &&
    ($past(rd_stb) || $past(wr_stb)) |-> (&ce_n) && $countones(~pe_n) == 1);
endmodule

bind bwbus_cedec bwbus_cedec_chk #(.N_CE(N_CE), .N_PE(N_PE)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .pf_rst     (pf_rst),
  .is_code    (is_code),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .msel_32k   (msel_32k),
  .part_en    (part_en),
  .pes        (pes),
  .addr       (addr),
  .bound      (bound),
  .ce_n       (ce_n),
  .pe_n       (pe_n),
  .we_n       (we_n),
  .ce1_code_n (ce1_code_n),
  .exp_acc    (exp_acc)
);

// File: tb/test_bwbus_cedec.sv
module test_bwbus_cedec;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        is_code, rd_stb, wr_stb;
  logic        msel_32k, part_en, pes, pf_rst;
  logic [15:0] bound, prog_top, data_top;
  logic [3:0]  ce_n, pe_n;
  logic [14:0] bus_addr;
  logic        we_n, ce1_code_n, exp_acc;

  int n_chk  = 0;
  int n_fail = 0;

  bwbus_cedec i_bwbus_cedec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_code(is_code),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .msel_32k(msel_32k),
    .part_en(part_en), .pes(pes), .pf_rst(pf_rst), .bound(bound),
    .prog_top(prog_top), .data_top(data_top), .ce_n(ce_n), .pe_n(pe_n),
    .bus_addr(bus_addr), .we_n(we_n), .ce1_code_n(ce1_code_n),
    .exp_acc(exp_acc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected word: {ce_n, pe_n, we_n, ce1_code_n, exp_acc}
  localparam logic [10:0] IDLE = {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [10:0] exp_v);
    logic [10:0] got;
    got = {ce_n, pe_n, we_n, ce1_code_n, exp_acc};
    n_chk++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp_v);
    end
  endtask

  task automatic chk_ba(input string req, input logic [14:0] exp_a);
    n_chk++;
    if (bus_addr !== exp_a) begin
      n_fail++;
      $display("FAIL %s: bus_addr got %h expected %h", req, bus_addr, exp_a);
    end
  endtask

  task automatic cfg(input logic m32, input logic pe, input logic ps,
                     input logic [15:0] bd, input logic [15:0] pt,
                     input logic [15:0] dt);
    @(negedge clk);
    msel_32k = m32; part_en = pe; pes = ps;
    bound = bd; prog_top = pt; data_top = dt;
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic acc(input logic c, input logic r, input logic w,
                     input logic [15:0] a);
    @(negedge clk);
    is_code = c; rd_stb = r; wr_stb = w; addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset outputs", IDLE);
    chk_ba("R1 reset bus address", 15'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_mem32;
    cfg(1, 0, 0, 16'h0000, 16'hFFFF, 16'hFFFF);
    acc(1, 1, 0, 16'h1234);
    chk("R2 code low block", {4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0});
    chk_ba("R2 bus address", 15'h1234);
    acc(1, 1, 0, 16'h9234);
    chk("R2 R11 code second block", {4'b1101, 4'b1111, 1'b1, 1'b1, 1'b0});
    chk_ba("R2 bus address high", 15'h1234);
    acc(0, 0, 1, 16'h0010);
    chk("R2 R5 data write third block", {4'b1011, 4'b1111, 1'b0, 1'b1, 1'b0});
    acc(0, 1, 0, 16'hC000);
    chk("R2 data read fourth block", {4'b0111, 4'b1111, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_idle;
    acc(0, 0, 0, 16'h1234);
    chk("R9 no strobe", IDLE);
  endtask

  task automatic t_range;
    cfg(1, 0, 0, 16'h0000, 16'h3FFF, 16'h7FFF);
    acc(1, 1, 0, 16'h4000);
    chk("R8 code above prog_top", {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1});
    acc(1, 1, 0, 16'h3FFF);
    chk("R8 code at prog_top", {4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0});
    acc(0, 1, 0, 16'h8000);
    chk("R8 data above data_top", {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1});
  endtask

  task automatic t_partition;
    cfg(1, 1, 0, 16'h6000, 16'hFFFF, 16'hFFFF);
    acc(0, 0, 1, 16'h5000);
    chk("R5 R10 write below bound", {4'b1110, 4'b1111, 1'b1, 1'b1, 1'b0});
    acc(0, 0, 1, 16'h6000);
    chk("R5 R10 write at bound", {4'b1110, 4'b1111, 1'b0, 1'b1, 1'b0});
    acc(0, 0, 1, 16'h9000);
    chk("R10 write upper half", {4'b1101, 4'b1111, 1'b0, 1'b1, 1'b0});
    acc(1, 1, 0, 16'h6000);
    chk("R8 code at bound", {4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1});
    acc(1, 1, 0, 16'h5FFF);
    chk("R10 R11 code below bound", {4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_mem128;
    cfg(0, 0, 0, 16'h0000, 16'hFFFF, 16'hFFFF);
    acc(1, 1, 0, 16'h9234);
    chk("R3 code upper half", {4'b1100, 4'b1111, 1'b1, 1'b1, 1'b0});
    acc(0, 0, 1, 16'h1234);
    chk("R3 data write", {4'b1010, 4'b1111, 1'b0, 1'b1, 1'b0});
    acc(1, 1, 0, 16'h0100);
    chk("R3 R11 code low", {4'b1000, 4'b1111, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_nopart128;
    cfg(0, 1, 0, 16'h6000, 16'hFFFF, 16'hFFFF);
    acc(0, 0, 1, 16'h1234);
    chk("R7 write below bound ignored", {4'b1010, 4'b1111, 1'b0, 1'b1, 1'b0});
    acc(1, 1, 0, 16'h7000);
    chk("R7 code above bound decoded", {4'b1000, 4'b1111, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_periph;
    cfg(1, 0, 1, 16'h0000, 16'hFFFF, 16'h0FFF);
    acc(0, 1, 0, 16'h0000);
    chk("R4 quadrant 0", {4'b1111, 4'b1110, 1'b1, 1'b1, 1'b0});
    acc(0, 0, 1, 16'hC123);
    chk("R4 quadrant 3 write", {4'b1111, 4'b0111, 1'b0, 1'b1, 1'b0});
    acc(0, 1, 0, 16'h5000);
    chk("R4 quadrant 1 beyond data_top", {4'b1111, 4'b1101, 1'b1, 1'b1, 1'b0});
    acc(1, 1, 0, 16'h1234);
    chk("R4 code unaffected", {4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0});
  endtask

  task automatic t_pwrfail;
    cfg(1, 0, 0, 16'h0000, 16'h3FFF, 16'hFFFF);
    pf_rst = 1'b1;
    acc(1, 1, 0, 16'h1234);
    chk("R6 R11 code copy survives", {4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0});
    acc(0, 0, 1, 16'h9000);
    chk("R6 write blocked", IDLE);
    acc(1, 1, 0, 16'h4000);
    chk("R6 no port-bus flag", IDLE);
    @(negedge clk) pf_rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    addr = '0; is_code = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    msel_32k = 1'b1; part_en = 1'b0; pes = 1'b0; pf_rst = 1'b0;
    bound = '0; prog_top = '1; data_top = '1;
    t_reset();
    t_mem32();
    t_idle();
    t_range();
    t_partition();
    t_mem128();
    t_nopart128();
    t_periph();
    t_pwrfail();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule